// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where each execute-stage source operand of a five-stage in-order pipeline should come from. It compares the two source register indices held in the decode-to-execute register with the destination index and write enable of the two older instructions still in flight. The older of the two sits in the memory stage and the oldest sits in writeback. For each operand it produces a 2-bit select and the chosen 32-bit value. The value comes from the register file, from the memory-stage result, or from the writeback value. When both older instructions target the same register, the younger memory-stage producer takes precedence.

A second path handles a same-cycle read-after-write at decode. When a decode read port names the register that writeback is writing in that cycle, the unit hands back the writeback value in place of the stale register-file contents. Register 0 is hard-wired to zero, so it is never forwarded on any path. The unit holds no state, and every output follows its inputs within the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select is 2'b10 and operand A value equals the memory-stage result when the memory-stage write enable is 1, its destination index is nonzero, and that index equals the operand A source index.
- R2: Operand A select is 2'b01 and operand A value equals the writeback value when the writeback write enable is 1, its destination is nonzero and equals the operand A source index, and the R1 condition is false.
- R3: When the R1 and R2 conditions both match the same operand, the memory-stage result wins (select 2'b10).
- R4: When neither condition holds, the operand select is 2'b00 and the operand value equals the register-file value supplied for it.
- R5: Operand B uses the same rules as operand A, evaluated with its own source index and independently of operand A.
- R6: A source index of 0 always yields select 2'b00, even when a producer with write enable 1 names register 0.
- R7: A producer whose write enable is 0 is never forwarded, even when its destination index matches.
- R8: For each decode read port, the bypass flag is 1 and the read data equals the writeback value when the writeback write enable is 1, its destination is nonzero, and it equals the read index. Otherwise the flag is 0 and the read data equals the register-file data.
- R9: A decode read of register 0 never takes the writeback bypass.
- R10: All outputs are combinational and respond to an input change within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Operand A source index in the decode/execute register |
| ex_src_b | input | 5 | Operand B source index in the decode/execute register |
| ex_rf_a | input | 32 | Register-file value latched for operand A |
| ex_rf_b | input | 32 | Register-file value latched for operand B |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | 5 | Memory-stage destination index |
| mem_res | input | 32 | Memory-stage result |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | 5 | Writeback-stage destination index |
| wb_val | input | 32 | Writeback value |
| dec_idx_a | input | 5 | Decode read port A index |
| dec_idx_b | input | 5 | Decode read port B index |
| dec_rf_a | input | 32 | Register-file read data, port A |
| dec_rf_b | input | 32 | Register-file read data, port B |
| ex_sel_a | output | 2 | Operand A select (00 file, 10 memory, 01 writeback) |
| ex_sel_b | output | 2 | Operand B select |
| ex_opnd_a | output | 32 | Selected operand A value |
| ex_opnd_b | output | 32 | Selected operand B value |
| dec_byp_a | output | 1 | Decode port A took the writeback value |
| dec_byp_b | output | 1 | Decode port B took the writeback value |
| dec_data_a | output | 32 | Decode port A data after bypass |
| dec_data_b | output | 32 | Decode port B data after bypass |

## Verification
The bench sweeps every combination of source index, memory-stage destination, writeback destination and both write enables over a set of indices that includes 0 and 31. Each output is compared against a model computed in the bench. The sweep targets the case where both producers name the same register; a design with the priority reversed would hand execute the older writeback value. It also drives producers that name register 0 with the write enable set, which a design without the zero check would forward as live data. Matches with the write enable low are covered too, where a design that ignores the enable would forward a stale result. A change made between clock edges confirms that the selects respond without waiting for a register stage.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect #(
  parameter int REG_W = fwd_pkg::REG_W
) (
  input  logic             prod_we,
  input  logic [REG_W-1:0] prod_rd,
  input  logic [REG_W-1:0] cons_idx,
  output logic             hit
);
  // A producer is usable only if it writes, targets a real register and matches.
  assign hit = prod_we && (prod_rd != '0) && (prod_rd == cons_idx);
endmodule

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
  import fwd_pkg::*;
#(
  parameter int REG_W  = fwd_pkg::REG_W,
  parameter int DATA_W = fwd_pkg::DATA_W
) (
  input  logic [REG_W-1:0]  src,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              mem_we,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic [DATA_W-1:0] mem_res,
  input  logic              wb_we,
  input  logic [REG_W-1:0]  wb_rd,
  input  logic [DATA_W-1:0] wb_val,
  output logic [1:0]        sel,
  output logic [DATA_W-1:0] val,
  output logic              mem_hit,
  output logic              wb_hit
);
  fwd_hit_detect #(.REG_W(REG_W)) u_mem_hit (
    .prod_we (mem_we),
    .prod_rd (mem_rd),
    .cons_idx(src),
    .hit     (mem_hit)
  );

  fwd_hit_detect #(.REG_W(REG_W)) u_wb_hit (
    .prod_we (wb_we),
    .prod_rd (wb_rd),
    .cons_idx(src),
    .hit     (wb_hit)
  );

  // Younger producer first.
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  always_comb begin
    unique case (sel)
      FWD_MEM: val = mem_res;
      FWD_WB:  val = wb_val;
      default: val = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_rf_bypass.sv
module fwd_rf_bypass #(
  parameter int REG_W  = fwd_pkg::REG_W,
  parameter int DATA_W = fwd_pkg::DATA_W
) (
  input  logic [REG_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              wb_we,
  input  logic [REG_W-1:0]  wb_rd,
  input  logic [DATA_W-1:0] wb_val,
  output logic              byp,
  output logic [DATA_W-1:0] data
);
  fwd_hit_detect #(.REG_W(REG_W)) u_hit (
    .prod_we (wb_we),
    .prod_rd (wb_rd),
    .cons_idx(rd_idx),
    .hit     (byp)
  );

  assign data = byp ? wb_val : rf_data;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = fwd_pkg::REG_W,
  parameter int DATA_W = fwd_pkg::DATA_W
) (
  input  logic [REG_W-1:0]  ex_src_a,
  input  logic [REG_W-1:0]  ex_src_b,
  input  logic [DATA_W-1:0] ex_rf_a,
  input  logic [DATA_W-1:0] ex_rf_b,
  input  logic              mem_we,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic [DATA_W-1:0] mem_res,
  input  logic              wb_we,
  input  logic [REG_W-1:0]  wb_rd,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [REG_W-1:0]  dec_idx_a,
  input  logic [REG_W-1:0]  dec_idx_b,
  input  logic [DATA_W-1:0] dec_rf_a,
  input  logic [DATA_W-1:0] dec_rf_b,
  output logic [1:0]        ex_sel_a,
  output logic [1:0]        ex_sel_b,
  output logic [DATA_W-1:0] ex_opnd_a,
  output logic [DATA_W-1:0] ex_opnd_b,
  output logic              dec_byp_a,
  output logic              dec_byp_b,
  output logic [DATA_W-1:0] dec_data_a,
  output logic [DATA_W-1:0] dec_data_b
);
  localparam int N_OPND = 2;
  localparam int N_RDP  = 2;

  logic [REG_W-1:0]  src_q   [N_OPND];
  logic [DATA_W-1:0] rf_q    [N_OPND];
  logic [1:0]        sel_q   [N_OPND];
  logic [DATA_W-1:0] val_q   [N_OPND];
  logic              mhit_q  [N_OPND];
  logic              whit_q  [N_OPND];

  logic [REG_W-1:0]  ridx_q  [N_RDP];
  logic [DATA_W-1:0] rdat_q  [N_RDP];
  logic              byp_q   [N_RDP];
  logic [DATA_W-1:0] bdat_q  [N_RDP];

  assign src_q[0] = ex_src_a;
  assign src_q[1] = ex_src_b;
  assign rf_q[0]  = ex_rf_a;
  assign rf_q[1]  = ex_rf_b;

  assign ridx_q[0] = dec_idx_a;
  assign ridx_q[1] = dec_idx_b;
  assign rdat_q[0] = dec_rf_a;
  assign rdat_q[1] = dec_rf_b;

  for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
    fwd_operand_select #(.REG_W(REG_W), .DATA_W(DATA_W)) u_sel (
      .src    (src_q[i]),
      .rf_val (rf_q[i]),
      .mem_we (mem_we),
      .mem_rd (mem_rd),
      .mem_res(mem_res),
      .wb_we  (wb_we),
      .wb_rd  (wb_rd),
      .wb_val (wb_val),
      .sel    (sel_q[i]),
      .val    (val_q[i]),
      .mem_hit(mhit_q[i]),
      .wb_hit (whit_q[i])
    );

    always_comb begin
      if (mhit_q[i] && whit_q[i])
        p_mem_wins_r3: assert (sel_q[i] == FWD_MEM);
      if (src_q[i] == '0)
        p_zero_src_r6: assert (sel_q[i] == FWD_RF);
      if (sel_q[i] == FWD_MEM)
        p_mem_data_r1: assert (val_q[i] == mem_res);
      if (sel_q[i] == FWD_WB)
        p_wb_data_r2: assert (val_q[i] == wb_val);
      if (!mem_we && !wb_we)
        p_no_we_r7: assert (sel_q[i] == FWD_RF && val_q[i] == rf_q[i]);
    end
  end

  for (genvar j = 0; j < N_RDP; j++) begin : g_rdp
    fwd_rf_bypass #(.REG_W(REG_W), .DATA_W(DATA_W)) u_byp (
      .rd_idx (ridx_q[j]),
      .rf_data(rdat_q[j]),
      .wb_we  (wb_we),
      .wb_rd  (wb_rd),
      .wb_val (wb_val),
      .byp    (byp_q[j]),
      .data   (bdat_q[j])
    );

    always_comb begin
      if (ridx_q[j] == '0)
        p_byp_zero_r9: assert (!byp_q[j] && bdat_q[j] == rdat_q[j]);
      if (byp_q[j])
        p_byp_data_r8: assert (bdat_q[j] == wb_val);
    end
  end

  assign ex_sel_a   = sel_q[0];
  assign ex_sel_b   = sel_q[1];
  assign ex_opnd_a  = val_q[0];
  assign ex_opnd_b  = val_q[1];
  assign dec_byp_a  = byp_q[0];
  assign dec_byp_b  = byp_q[1];
  assign dec_data_a = bdat_q[0];
  assign dec_data_b = bdat_q[1];
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [4:0]  ex_src_a, ex_src_b, mem_rd, wb_rd, dec_idx_a, dec_idx_b;
  logic [31:0] ex_rf_a, ex_rf_b, mem_res, wb_val, dec_rf_a, dec_rf_b;
  logic        mem_we, wb_we;
  logic [1:0]  ex_sel_a, ex_sel_b;
  logic [31:0] ex_opnd_a, ex_opnd_b, dec_data_a, dec_data_b;
  logic        dec_byp_a, dec_byp_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_unit dut_i (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .mem_we(mem_we), .mem_rd(mem_rd), .mem_res(mem_res),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_val(wb_val),
    .dec_idx_a(dec_idx_a), .dec_idx_b(dec_idx_b), .dec_rf_a(dec_rf_a), .dec_rf_b(dec_rf_b),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
    .dec_byp_a(dec_byp_a), .dec_byp_b(dec_byp_b), .dec_data_a(dec_data_a), .dec_data_b(dec_data_b)
  );

  function automatic logic [4:0] pick(input int k);
    return (k == 7) ? 5'd31 : 5'(k);
  endfunction

  function automatic bit hit(input logic we, input logic [4:0] rd, input logic [4:0] s);
    return we && rd != 5'd0 && rd == s;
  endfunction

  function automatic logic [1:0] model_sel(input logic [4:0] s);
    if (hit(mem_we, mem_rd, s)) return 2'b10;
    if (hit(wb_we, wb_rd, s))   return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] model_val(input logic [1:0] sl, input logic [31:0] rf);
    return (sl == 2'b10) ? mem_res : (sl == 2'b01) ? wb_val : rf;
  endfunction

  function automatic string tag_for(input logic [4:0] s);
    if (s == 5'd0) return "R6";
    if (hit(mem_we, mem_rd, s) && hit(wb_we, wb_rd, s)) return "R3";
    if (hit(mem_we, mem_rd, s)) return "R1";
    if (hit(wb_we, wb_rd, s)) return "R2";
    if ((s == mem_rd && !mem_we) || (s == wb_rd && !wb_we)) return "R7";
    return "R4";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag_a);
    logic [1:0] sa, sb;
    bit ba, bb;
    sa = model_sel(ex_src_a);
    sb = model_sel(ex_src_b);
    check(tag_a, "sel_a", 32'(ex_sel_a), 32'(sa));
    check(tag_a, "opnd_a", ex_opnd_a, model_val(sa, ex_rf_a));
    check("R5", "sel_b", 32'(ex_sel_b), 32'(sb));
    check("R5", "opnd_b", ex_opnd_b, model_val(sb, ex_rf_b));
    ba = hit(wb_we, wb_rd, dec_idx_a);
    bb = hit(wb_we, wb_rd, dec_idx_b);
    check(dec_idx_a == 0 ? "R9" : "R8", "byp_a", 32'(dec_byp_a), 32'(ba));
    check(dec_idx_a == 0 ? "R9" : "R8", "dec_a", dec_data_a, ba ? wb_val : dec_rf_a);
    check(dec_idx_b == 0 ? "R9" : "R8", "byp_b", 32'(dec_byp_b), 32'(bb));
    check(dec_idx_b == 0 ? "R9" : "R8", "dec_b", dec_data_b, bb ? wb_val : dec_rf_b);
  endtask

  initial begin
    ex_src_a = '0; ex_src_b = '0; mem_rd = '0; wb_rd = '0;
    dec_idx_a = '0; dec_idx_b = '0; mem_we = 1'b0; wb_we = 1'b0;
    ex_rf_a = 32'h1111_0000; ex_rf_b = 32'h2222_0000;
    mem_res = 32'hAAAA_0000; wb_val = 32'hBBBB_0000;
    dec_rf_a = 32'hCCCC_0000; dec_rf_b = 32'hDDDD_0000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    check("R4", "reset sel_a", 32'(ex_sel_a), 32'h0);
    check("R4", "reset opnd_a", ex_opnd_a, 32'h1111_0000);

    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++)
          for (int e = 0; e < 4; e++) begin
            @(posedge clk); #2;
            ex_src_a  = pick(s);
            ex_src_b  = pick((s + m + 3) % 8);
            mem_rd    = pick(m);
            wb_rd     = pick(w);
            mem_we    = e[0];
            wb_we     = e[1];
            dec_idx_a = pick(s);
            dec_idx_b = pick((w + e) % 8);
            ex_rf_a   = 32'h1000_0000 | 32'(s * 64 + m * 8 + w);
            ex_rf_b   = 32'h2000_0000 | 32'(e);
            mem_res   = 32'h3000_0000 | 32'(m * 4 + e);
            wb_val    = 32'h4000_0000 | 32'(w * 4 + e);
            dec_rf_a  = 32'h5000_0000 | 32'(s);
            dec_rf_b  = 32'h6000_0000 | 32'(w);
            #3;
            check_all(tag_for(ex_src_a));
          end

    // R10: change between edges, no clock in between
    @(posedge clk); #2;
    ex_src_a = 5'd9; mem_we = 1'b1; mem_rd = 5'd3; wb_we = 1'b0;
    #1;
    check("R10", "sel_a before change", 32'(ex_sel_a), 32'h0);
    mem_rd = 5'd9;
    #1;
    check("R10", "sel_a same cycle", 32'(ex_sel_a), 32'h2);
    check("R10", "opnd_a same cycle", ex_opnd_a, mem_res);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule